// File: doc/BRIEF.md
# Protected Segment Range Checker

This block screens every core memory request address against one protected window in physical address space. Software sets up the window through a small register port. A base register gives the window position. A mask register selects which address bits must equal the base. An enable bit turns the check on, and a lock bit freezes the window geometry. When the check is on and a request address falls inside the window, the block raises a registered abort flag one clock later. Delivering that abort is left to the surrounding logic.

Only address bits from `LSB` up to `ADDR_W-1` take part in the comparison. With the default values these are bits 39 down to 19, so the window is at least 512 KB. Software should program a power-of-two sized window that is aligned to its own size. To do that, the mask holds ones on a contiguous run of high bits, and the base has zeros wherever the mask has zeros. Once the lock bit is written to 1, the base and mask are read-only until reset. The enable bit stays writable while locked.

Top module: `prot_seg_checker`

## Requirements
- R1: After reset, all registers read 0: the enable, lock, base and mask are all clear. The `abort_hit` output is 0.
- R2: The register selector `wr_sel`/`rd_sel` picks one of four registers. Value 0 is control, with enable in data bit 0 and lock in data bit 1. Value 1 is the base, held in data bits `ADDR_W-1:LSB`. Value 2 is the mask, held in the same bit positions as the base. Value 3 selects nothing and reads 0. A write to a writable field can be read back on the next cycle.
- R3: Every data bit outside the fields listed in R2 reads as 0, and writes to those bits have no effect.
- R4: An address lies inside the window when, at every bit position from `LSB` to `ADDR_W-1` where the mask is 1, the address bit equals the base bit. Address bits below `LSB` never affect the result.
- R5: `abort_hit` is registered. It is 1 in the cycle after a cycle in which all three hold: `req_valid` is high, enable is set, and the address lies inside the window. In every other case it is 0, including cycles after one with `req_valid` low.
- R6: While the enable bit is clear, `abort_hit` stays 0 for any address.
- R7: While lock is set, writes to the base and mask registers are ignored. The enable bit remains writable.
- R8: Lock is sticky. Writing 0 to it has no effect, and only reset clears it.
- R9: With a mask of all zeros and enable set, every valid request is aborted.
- R10: A register write committed on a clock edge applies to a request presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | REG_W | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | REG_W | Read data for `rd_sel`, combinational |
| req_valid | input | 1 | A request address is present |
| req_addr | input | ADDR_W | Physical address of the request |
| abort_hit | output | 1 | Registered abort flag for the previous cycle's request |

## Verification
The bench builds the block with its default parameters: a 40-bit address, a field starting at bit 19, and a 64-bit register word. With these values it can reach the top address bit 39 and the boundary between bits 19 and 18, where comparison starts. It also reaches reserved bits on both sides of the field and above bit 39. Window tests cover the smallest 512 KB window, with every mask bit set, as well as a 1 GB window and the all-zero mask. They probe addresses one byte inside and one byte outside each window edge.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_LOCK_BIT = 1;
    localparam int CTRL_W        = 2;

endpackage

// File: rtl/psr_regs.sv
module psr_regs #(
    parameter int ADDR_W = 40,
    parameter int LSB    = 19,
    parameter int REG_W  = 64,
    localparam int FW    = ADDR_W - LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             en_o,
    output logic [FW-1:0]    base_o,
    output logic [FW-1:0]    mask_o
);
    import psr_pkg::*;

    typedef struct packed {
        logic          en;
        logic          lock;
        logic [FW-1:0] base;
        logic [FW-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-1:ADDR_W], wr_data[LSB-1:CTRL_W]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    st_d.en = wr_data[CTRL_EN_BIT];
                    if (wr_data[CTRL_LOCK_BIT]) st_d.lock = 1'b1;
                end
                SEL_BASE: if (!st_q.lock) st_d.base = wr_data[ADDR_W-1:LSB];
                SEL_MASK: if (!st_q.lock) st_d.mask = wr_data[ADDR_W-1:LSB];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL: begin
                rd_data[CTRL_EN_BIT]   = st_q.en;
                rd_data[CTRL_LOCK_BIT] = st_q.lock;
            end
            SEL_BASE: rd_data[ADDR_W-1:LSB] = st_q.base;
            SEL_MASK: rd_data[ADDR_W-1:LSB] = st_q.mask;
            default: ;
        endcase
    end

    assign en_o   = st_q.en;
    assign base_o = st_q.base;
    assign mask_o = st_q.mask;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R8
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.base) && $stable(st_q.mask))); // R7
    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_CTRL) |-> (rd_data[REG_W-1:CTRL_W] == '0)); // R3

endmodule

// File: rtl/psr_match.sv
module psr_match #(
    parameter int ADDR_W = 40,
    parameter int LSB    = 19,
    localparam int FW    = ADDR_W - LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              en_i,
    input  logic [FW-1:0]     base_i,
    input  logic [FW-1:0]     mask_i,
    output logic              hit_o
);
    typedef struct packed {
        logic hit;
    } match_t;

    match_t st_d, st_q;
    logic [FW-1:0] miss;

    logic unused_low_addr;
    assign unused_low_addr = ^req_addr[LSB-1:0];

    for (genvar i = 0; i < FW; i++) begin : g_bit
        assign miss[i] = mask_i[i] & (req_addr[LSB+i] ^ base_i[i]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = req_valid & en_i & ~(|miss);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.hit;

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !hit_o); // R5
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hit_o); // R6
    AST_OPEN_MASK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en_i && mask_i == '0) |=> hit_o); // R9

endmodule

// File: rtl/prot_seg_checker.sv
module prot_seg_checker #(
    parameter int ADDR_W = 40,
    parameter int LSB    = 19,
    parameter int REG_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              abort_hit
);
    localparam int FW = ADDR_W - LSB;

    logic          en;
    logic [FW-1:0] base;
    logic [FW-1:0] mask;

    psr_regs #(.ADDR_W(ADDR_W), .LSB(LSB), .REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .en_o    (en),
        .base_o  (base),
        .mask_o  (mask)
    );

    psr_match #(.ADDR_W(ADDR_W), .LSB(LSB)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .en_i      (en),
        .base_i    (base),
        .mask_i    (mask),
        .hit_o     (abort_hit)
    );

    AST_RD_RSVD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:ADDR_W] == '0); // R3

endmodule

// File: tb/prot_seg_checker_bench.sv
module prot_seg_checker_bench;
    localparam int ADDR_W = 40;
    localparam int LSB    = 19;
    localparam int REG_W  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [REG_W-1:0]  wr_data = '0;
    logic [1:0]        rd_sel = '0;
    logic [REG_W-1:0]  rd_data;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              abort_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prot_seg_checker #(.ADDR_W(ADDR_W), .LSB(LSB), .REG_W(REG_W)) u_prot_seg_checker (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid),
        .req_addr(req_addr), .abort_hit(abort_hit)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(logic [1:0] sel, logic [63:0] data);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_chk(string req, logic [1:0] sel, logic [63:0] exp);
        rd_sel = sel; #1;
        chk(req, rd_data, exp);
    endtask

    task automatic req_chk(string req, logic [39:0] addr, logic v, logic exp);
        @(negedge clk); req_valid = v; req_addr = addr;
        @(negedge clk); chk(req, {63'd0, abort_hit}, {63'd0, exp});
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1 ctrl", 2'd0, 64'd0);
        rd_chk("R1 base", 2'd1, 64'd0);
        rd_chk("R1 mask", 2'd2, 64'd0);
        chk("R1 abort", {63'd0, abort_hit}, 64'd0);
    endtask

    task automatic t_regs();
        wr(2'd1, 64'h0000_0012_3458_0000 | 64'hFFFF_FF00_0007_FFFF);
        rd_chk("R2 base readback", 2'd1, 64'h0000_0012_3458_0000);
        wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R3 mask reserved", 2'd2, 64'h0000_00FF_FFF8_0000);
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFC);
        rd_chk("R3 ctrl reserved", 2'd0, 64'd0);
        wr(2'd0, 64'd1);
        rd_chk("R2 ctrl enable", 2'd0, 64'd1);
        rd_chk("R2 sel3 zero", 2'd3, 64'd0);
    endtask

    task automatic t_small_window();
        req_chk("R4 base hit",    40'h12_3458_0000, 1'b1, 1'b1);
        req_chk("R4 low bits",    40'h12_345F_FFFF, 1'b1, 1'b1);
        req_chk("R4 bit19 miss",  40'h12_3460_0000, 1'b1, 1'b0);
        req_chk("R4 below miss",  40'h12_3457_FFFF, 1'b1, 1'b0);
        req_chk("R4 bit39 miss",  40'h92_3458_0000, 1'b1, 1'b0);
        req_chk("R5 idle",        40'h12_3458_0000, 1'b0, 1'b0);
    endtask

    task automatic t_big_window();
        wr(2'd1, 64'h0000_00AB_C000_0000);
        wr(2'd2, 64'h0000_00FF_C000_0000);
        req_chk("R4 big top edge",  40'hAB_FFFF_FFFF, 1'b1, 1'b1);
        req_chk("R4 big above",     40'hAC_0000_0000, 1'b1, 1'b0);
        req_chk("R4 big below",     40'hAB_BFFF_FFFF, 1'b1, 1'b0);
        // R5: a hit lasts one cycle only
        @(negedge clk); req_valid = 1'b1; req_addr = 40'hAB_C000_0000;
        @(negedge clk); req_valid = 1'b0;
        chk("R5 hit pulse", {63'd0, abort_hit}, 64'd1);
        @(negedge clk); chk("R5 hit drops", {63'd0, abort_hit}, 64'd0);
    endtask

    task automatic t_disable();
        wr(2'd0, 64'd0);
        req_chk("R6 disabled inside", 40'hAB_C123_4567, 1'b1, 1'b0);
        wr(2'd2, 64'd0);
        req_chk("R6 disabled open",   40'h00_0000_0000, 1'b1, 1'b0);
        wr(2'd0, 64'd1);
        req_chk("R9 open mask low",   40'h00_0000_0000, 1'b1, 1'b1);
        req_chk("R9 open mask high",  40'hFF_FFFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_immediate();
        wr(2'd2, 64'h0000_00FF_FFF8_0000);
        wr(2'd1, 64'h0000_0001_0000_0000);
        // R10: write committed at edge, request in the very next cycle
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd1; wr_data = 64'h0000_0002_0000_0000;
        @(negedge clk); wr_en = 1'b0; req_valid = 1'b1; req_addr = 40'h02_0000_0000;
        @(negedge clk); req_valid = 1'b0;
        chk("R10 new base used", {63'd0, abort_hit}, 64'd1);
    endtask

    task automatic t_lock();
        wr(2'd0, 64'd3);
        rd_chk("R7 lock set", 2'd0, 64'd3);
        wr(2'd1, 64'h0000_0055_5550_0000);
        rd_chk("R7 base frozen", 2'd1, 64'h0000_0002_0000_0000);
        wr(2'd2, 64'd0);
        rd_chk("R7 mask frozen", 2'd2, 64'h0000_00FF_FFF8_0000);
        req_chk("R7 window kept", 40'h02_0000_1234, 1'b1, 1'b1);
        wr(2'd0, 64'd0);
        rd_chk("R8 lock sticky", 2'd0, 64'd2);
        req_chk("R7 enable writable", 40'h02_0000_1234, 1'b1, 1'b0);
        wr(2'd0, 64'd1);
        rd_chk("R7 enable relit", 2'd0, 64'd3);
        do_reset();
        rd_chk("R8 reset clears lock", 2'd0, 64'd0);
        wr(2'd1, 64'h0000_0055_5550_0000);
        rd_chk("R8 base writable again", 2'd1, 64'h0000_0055_5550_0000);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_small_window();
        t_big_window();
        t_disable();
        t_immediate();
        t_lock();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule